// File: doc/BRIEF.md
# Latched Status Interrupt Controller

This block collects four event sources of a line framer into one host-visible status byte and one interrupt line. Three sources are live level inputs from detectors elsewhere: loss of the receive clock, loss of the transmit clock, and an error-counter overflow. Each is edge-captured: a low-to-high change sets a sticky bit, and the bit stays set until software clears it. The fourth source is a one-second boundary made by an internal divider. The divider counts tick pulses from one of two clock sources, and a select input picks which source it counts.

A host reaches the block through a byte-wide register bus. It reads the sticky bits, clears them by writing ones, and programs a per-bit enable mask. The interrupt output is a registered OR of every sticky bit whose enable is set. The tick inputs are single-cycle pulses, already brought into the block's clock domain, one pulse for each period of their source clock. The divider length is a parameter, so a short run can use a small count.

Top module: `stat_irq_ctrl`

## Requirements
- R1: The status byte reads at address 0x09 with receive-clock loss in bit 7, transmit-clock loss in bit 6, counter overflow in bit 1 and the one-second boundary in bit 0. Bits 5 to 2 read 0. The enable byte reads and writes at address 0x0A with the same bit positions, and its bits 5 to 2 ignore writes and read 0. Any other address reads 0x00.
- R2: A low-to-high change on rxClkLoss, txClkLoss or cntOvf sets its status bit at the next clock edge. An input that stays high does not set the bit again after it has been cleared.
- R3: A set status bit stays set until the host clears it.
- R4: Writing a 1 to a status bit position clears that bit. Writing a 0 leaves it unchanged.
- R5: The one-second bit is set when the divider counts its TICKS_PER_SEC-th pulse of the selected tick. tmrSrcSel=0 selects rxTick and tmrSrcSel=1 selects txTick. Pulses on the tick that is not selected are not counted.
- R6: irq is 1 exactly when some status bit and its enable bit are both 1. It is registered and changes on the same clock edge as the status and enable bits.
- R7: irq falls on the clock edge that clears the last enabled status bit or its enable bit.
- R8: When a set event and a write-1 clear hit the same bit in the same cycle, the bit ends up 1.
- R9: Reset clears every status bit, every enable bit, irq and the divider count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 = write cycle when busSel is 1 |
| busAddr | input | ADDR_W | Register byte address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr (combinational) |
| rxClkLoss | input | 1 | Live receive-clock-loss status |
| txClkLoss | input | 1 | Live transmit-clock-loss status |
| cntOvf | input | 1 | Live counter-overflow status |
| tmrSrcSel | input | 1 | Divider source: 0 receive tick, 1 transmit tick |
| rxTick | input | 1 | One pulse per receive clock period |
| txTick | input | 1 | One pulse per transmit clock period |
| irq | output | 1 | Active-high interrupt |

## Verification
The assertions check several rules on every cycle. The interrupt must always equal the OR of the enabled status bits. A rising live input must always leave its bit set, even when a clear hits in the same cycle. A bit must hold unless a write-1 clear targets it, and the unused read bits must stay zero. Other behaviour shows only in the bench's scenarios: the divider's period, its source selection, reset clearing a count that is part-way through, and the full register map of both bytes.

// File: rtl/sic_pkg.sv
package sic_pkg;

  localparam int NUM_SRC = 4;
  localparam int IDX_SEC = 0;
  localparam int IDX_OVF = 1;
  localparam int IDX_TX  = 2;
  localparam int IDX_RX  = 3;
  localparam int NUM_LIVE = 3;

  // Strobes from control to datapath, one cycle wide
  typedef struct packed {
    logic [NUM_SRC-1:0] setEv;
    logic [NUM_SRC-1:0] clrMask;
    logic               enaWr;
    logic [NUM_SRC-1:0] enaData;
    logic               rdStat;
    logic               rdEna;
  } sicStrobe_t;

  // Compact 4-bit vector <-> byte image (bits 7,6,1,0)
  function automatic logic [7:0] packByte(logic [NUM_SRC-1:0] v);
    packByte = {v[IDX_RX], v[IDX_TX], 4'b0000, v[IDX_OVF], v[IDX_SEC]};
  endfunction

  function automatic logic [NUM_SRC-1:0] unpackByte(logic [7:0] b);
    unpackByte = {b[7], b[6], b[1], b[0]};
  endfunction

endpackage

// File: rtl/sic_sec_div.sv
module sic_sec_div #(
  parameter int TICKS_PER_SEC = 44736
) (
  input  logic clk,
  input  logic rstN,
  input  logic srcSel,
  input  logic rxTick,
  input  logic txTick,
  output logic secPulse
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] count;
  logic          tickSel;

  assign tickSel  = srcSel ? txTick : rxTick;
  assign secPulse = tickSel && (count == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (tickSel) begin
      if (secPulse) count <= '0;
      else          count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/sic_ctrl.sv
module sic_ctrl
  import sic_pkg::*;
#(
  parameter int              ADDR_W        = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = ADDR_W'(9),
  parameter logic [ADDR_W-1:0] ENA_ADDR    = ADDR_W'(10),
  parameter int              TICKS_PER_SEC = 44736
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  input  logic [NUM_LIVE-1:0] liveIn,   // [0] ovf, [1] tx loss, [2] rx loss
  input  logic              tmrSrcSel,
  input  logic              rxTick,
  input  logic              txTick,
  output sicStrobe_t        strobe
);
  logic [NUM_LIVE-1:0] liveQ;
  logic [NUM_LIVE-1:0] liveRise;
  logic                secPulse;
  logic                statWrite;
  logic                enaWrite;

  sic_sec_div #(.TICKS_PER_SEC(TICKS_PER_SEC)) secDiv_i (
    .clk      (clk),
    .rstN     (rstN),
    .srcSel   (tmrSrcSel),
    .rxTick   (rxTick),
    .txTick   (txTick),
    .secPulse (secPulse)
  );

  // One edge detector per live input
  for (genvar g = 0; g < NUM_LIVE; g++) begin : gEdge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) liveQ[g] <= 1'b0;
      else       liveQ[g] <= liveIn[g];
    end
    assign liveRise[g] = liveIn[g] & ~liveQ[g];
  end

  assign statWrite = busSel && busWr && (busAddr == STAT_ADDR);
  assign enaWrite  = busSel && busWr && (busAddr == ENA_ADDR);

  always_comb begin
    strobe          = '0;
    strobe.setEv    = {liveRise, secPulse};
    strobe.clrMask  = statWrite ? unpackByte(busWrData) : '0;
    strobe.enaWr    = enaWrite;
    strobe.enaData  = unpackByte(busWrData);
    strobe.rdStat   = (busAddr == STAT_ADDR);
    strobe.rdEna    = (busAddr == ENA_ADDR);
  end
endmodule

// File: rtl/sic_dpath.sv
module sic_dpath
  import sic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  sicStrobe_t         strobe,
  output logic [NUM_SRC-1:0] statVec,
  output logic [NUM_SRC-1:0] enaVec,
  output logic               irq,
  output logic [7:0]         rdData
);
  logic [NUM_SRC-1:0] statNext;
  logic [NUM_SRC-1:0] enaNext;
  logic               irqQ;

  // Per-bit sticky latch: set has priority over clear
  for (genvar g = 0; g < NUM_SRC; g++) begin : gBit
    assign statNext[g] = strobe.setEv[g] | (statVec[g] & ~strobe.clrMask[g]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) statVec[g] <= 1'b0;
      else       statVec[g] <= statNext[g];
    end
  end

  assign enaNext = strobe.enaWr ? strobe.enaData : enaVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enaVec <= '0;
      irqQ   <= 1'b0;
    end else begin
      enaVec <= enaNext;
      irqQ   <= |(statNext & enaNext);
    end
  end

  assign irq = irqQ;

  always_comb begin
    if (strobe.rdStat)     rdData = packByte(statVec);
    else if (strobe.rdEna) rdData = packByte(enaVec);
    else                   rdData = 8'h00;
  end
endmodule

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl
  import sic_pkg::*;
#(
  parameter int                ADDR_W        = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR     = ADDR_W'(9),
  parameter logic [ADDR_W-1:0] ENA_ADDR      = ADDR_W'(10),
  parameter int                TICKS_PER_SEC = 44736
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic              rxClkLoss,
  input  logic              txClkLoss,
  input  logic              cntOvf,
  input  logic              tmrSrcSel,
  input  logic              rxTick,
  input  logic              txTick,
  output logic              irq
);
  sicStrobe_t         strobe;
  logic [NUM_SRC-1:0] statVec;
  logic [NUM_SRC-1:0] enaVec;

  sic_ctrl #(
    .ADDR_W        (ADDR_W),
    .STAT_ADDR     (STAT_ADDR),
    .ENA_ADDR      (ENA_ADDR),
    .TICKS_PER_SEC (TICKS_PER_SEC)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .busSel    (busSel),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .liveIn    ({rxClkLoss, txClkLoss, cntOvf}),
    .tmrSrcSel (tmrSrcSel),
    .rxTick    (rxTick),
    .txTick    (txTick),
    .strobe    (strobe)
  );

  sic_dpath dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .statVec (statVec),
    .enaVec  (enaVec),
    .irq     (irq),
    .rdData  (busRdData)
  );
endmodule

// File: rtl/sic_chk.sv
module sic_chk
  import sic_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(9)
) (
  input logic               clk,
  input logic               rstN,
  input logic               busSel,
  input logic               busWr,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [7:0]         busWrData,
  input logic [7:0]         busRdData,
  input logic               rxClkLoss,
  input logic               txClkLoss,
  input logic               cntOvf,
  input logic               irq,
  input logic [NUM_SRC-1:0] statVec,
  input logic [NUM_SRC-1:0] enaVec
);
  logic               hostClr;
  logic [NUM_SRC-1:0] clrBits;

  assign hostClr = busSel && busWr && (busAddr == STAT_ADDR);
  assign clrBits = hostClr ? {busWrData[7], busWrData[6], busWrData[1], busWrData[0]} : '0;

  // R1: unused status bits read zero
  a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == STAT_ADDR) |-> (busRdData[5:2] == 4'b0000));

  // R2: rising live inputs set their bit
  a_r2_rx_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxClkLoss) |=> statVec[IDX_RX]);
  a_r2_tx_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txClkLoss) |=> statVec[IDX_TX]);

  // R3: sticky unless cleared
  for (genvar g = 0; g < NUM_SRC; g++) begin : gHold
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (statVec[g] && !clrBits[g]) |=> statVec[g]);
  end

  // R4: write-1 clear without a competing edge
  a_r4_clear_rx: assert property (@(posedge clk) disable iff (!rstN)
    (clrBits[IDX_RX] && !$rose(rxClkLoss)) |=> !statVec[IDX_RX]);

  // R6: interrupt equals OR of enabled bits
  a_r6_irq_or: assert property (@(posedge clk) disable iff (!rstN)
    irq == |(statVec & enaVec));

  // R8: set beats clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cntOvf) && clrBits[IDX_OVF]) |=> statVec[IDX_OVF]);
endmodule

bind stat_irq_ctrl sic_chk #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .busSel    (busSel),
  .busWr     (busWr),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .rxClkLoss (rxClkLoss),
  .txClkLoss (txClkLoss),
  .cntOvf    (cntOvf),
  .irq       (irq),
  .statVec   (statVec),
  .enaVec    (enaVec)
);

// File: tb/stat_irq_ctrl_tb_top.sv
module stat_irq_ctrl_tb_top;
  localparam int         TPS  = 4;
  localparam logic [7:0] STAT = 8'h09;
  localparam logic [7:0] ENA  = 8'h0A;

  typedef struct packed {
    logic       rx;
    logic       tx;
    logic       ovf;
    logic       wr;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic [7:0] expStat;
    logic       expIrq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, STAT, 8'h00, 8'h80, 1'b0}, // R2 rise sets rx
    '{1'b1, 1'b0, 1'b0, 1'b1, STAT, 8'h80, 8'h00, 1'b0}, // R4 clear
    '{1'b1, 1'b0, 1'b0, 1'b0, STAT, 8'h00, 8'h00, 1'b0}, // R2 no re-set while high
    '{1'b0, 1'b0, 1'b0, 1'b0, STAT, 8'h00, 8'h00, 1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b0, STAT, 8'h00, 8'h80, 1'b0}, // R2 new edge
    '{1'b1, 1'b0, 1'b0, 1'b1, ENA,  8'h80, 8'h80, 1'b1}, // R6 enable
    '{1'b1, 1'b1, 1'b0, 1'b0, STAT, 8'h00, 8'hC0, 1'b1}, // R2 tx
    '{1'b1, 1'b1, 1'b0, 1'b1, STAT, 8'h40, 8'h80, 1'b1}, // R4 zero keeps rx
    '{1'b1, 1'b1, 1'b0, 1'b1, ENA,  8'h00, 8'h80, 1'b0}, // R7 enable cleared
    '{1'b1, 1'b1, 1'b1, 1'b0, STAT, 8'h00, 8'h82, 1'b0}, // R2 ovf
    '{1'b1, 1'b1, 1'b1, 1'b1, ENA,  8'h02, 8'h82, 1'b1}, // R6
    '{1'b1, 1'b1, 1'b1, 1'b1, STAT, 8'h02, 8'h80, 1'b0}, // R7 bit cleared
    '{1'b1, 1'b1, 1'b0, 1'b1, STAT, 8'hFF, 8'h00, 1'b0}, // R3/R4 clear all
    '{1'b1, 1'b1, 1'b1, 1'b1, STAT, 8'h02, 8'h02, 1'b1}  // R8 set wins
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       busSel, busWr;
  logic [7:0] busAddr, busWrData, busRdData;
  logic       rxClkLoss, txClkLoss, cntOvf;
  logic       tmrSrcSel, rxTick, txTick;
  logic       irq;
  int         nChecks = 0;
  int         nErrors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  stat_irq_ctrl #(.TICKS_PER_SEC(TPS)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .rxClkLoss(rxClkLoss),
    .txClkLoss(txClkLoss), .cntOvf(cntOvf), .tmrSrcSel(tmrSrcSel),
    .rxTick(rxTick), .txTick(txTick), .irq(irq)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic readReg(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic writeReg(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic pulse(bit useTx, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (useTx) txTick = 1'b1; else rxTick = 1'b1;
      @(negedge clk);
      txTick = 1'b0; rxTick = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rstN = 1'b0; busSel = 1'b0; busWr = 1'b0; busAddr = STAT; busWrData = 8'h00;
    rxClkLoss = 1'b0; txClkLoss = 1'b0; cntOvf = 1'b0;
    tmrSrcSel = 1'b0; rxTick = 1'b0; txTick = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R9 reset state
    readReg(STAT, d); check("R9 status after reset", d, 8'h00);
    readReg(ENA, d);  check("R9 enable after reset", d, 8'h00);
    check("R9 irq after reset", {7'b0, irq}, 8'h00);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rxClkLoss = VECS[i].rx; txClkLoss = VECS[i].tx; cntOvf = VECS[i].ovf;
      busSel = VECS[i].wr; busWr = VECS[i].wr;
      busAddr = VECS[i].wr ? VECS[i].addr : STAT; busWrData = VECS[i].wdata;
      @(negedge clk);
      busSel = 1'b0; busWr = 1'b0; busAddr = STAT;
      #1;
      check($sformatf("R1/R2/R4/R6/R7/R8 vector %0d status", i), busRdData, VECS[i].expStat);
      check($sformatf("R6/R7 vector %0d irq", i), {7'b0, irq}, {7'b0, VECS[i].expIrq});
    end

    // R5 divider with receive source
    rxClkLoss = 1'b0; txClkLoss = 1'b0; cntOvf = 1'b0;
    writeReg(STAT, 8'hFF);
    pulse(1'b1, TPS);
    readReg(STAT, d); check("R5 unselected tick ignored", d, 8'h00);
    pulse(1'b0, TPS - 1);
    readReg(STAT, d); check("R5 before boundary", d, 8'h00);
    pulse(1'b0, 1);
    readReg(STAT, d); check("R5 boundary on rx", d, 8'h01);
    writeReg(STAT, 8'h01);
    readReg(STAT, d); check("R4 second clear", d, 8'h00);

    // R5 transmit source
    tmrSrcSel = 1'b1;
    pulse(1'b0, TPS);
    readReg(STAT, d); check("R5 rx ignored when tx selected", d, 8'h00);
    pulse(1'b1, TPS - 1);
    readReg(STAT, d); check("R5 tx before boundary", d, 8'h00);
    pulse(1'b1, 1);
    readReg(STAT, d); check("R5 boundary on tx", d, 8'h01);

    // R1 enable map
    writeReg(ENA, 8'hFF);
    readReg(ENA, d); check("R1 enable unused bits", d, 8'hC3);
    check("R6 irq from one-second bit", {7'b0, irq}, 8'h01);
    readReg(8'h00, d); check("R1 unmapped address", d, 8'h00);

    // R9 reset clears partial count
    writeReg(STAT, 8'h01);
    pulse(1'b1, 2);
    @(negedge clk) rstN = 1'b0;
    @(negedge clk) rstN = 1'b1;
    readReg(ENA, d); check("R9 enable cleared", d, 8'h00);
    pulse(1'b1, TPS - 1);
    readReg(STAT, d); check("R9 count restarted", d, 8'h00);
    pulse(1'b1, 1);
    readReg(STAT, d); check("R9 boundary after reset", d, 8'h01);
    check("R9 irq stays low with enables cleared", {7'b0, irq}, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule